// File: doc/BRIEF.md
# Shader Program Sequencer

This block steps through a small shader program held in a private 1024-word instruction store and hands each arithmetic instruction to an external vector ALU. The store is filled while the sequencer is idle. A pointer-reset strobe sets the store's write pointer back to word zero. Each write strobe then places one 32-bit word at the pointer and moves the pointer on by one. In the register space that feeds the block, eight addresses alias to that single write strobe.

A start pulse begins a run at the word given by the entry-offset input. Each cycle the sequencer reads the word at its program counter and decodes the opcode in the top six bits. An arithmetic instruction goes out as a one-cycle issue strobe, carrying the opcode and the instruction's address. A call saves the current address on an eight-deep return stack and jumps. A return resumes one word after the saved address. There is no end instruction: a return with an empty stack ends the program, and the block then raises a one-cycle done pulse.

Two error outputs cover misuse. An unknown opcode gives a one-cycle flag and is skipped. A call made with a full stack sets a flag that stays high and ends the run.

Top module: `shader_seq`

## Requirements
- R1: The opcode is instruction bits 31:26. The arithmetic codes are 0x00 add, 0x01 three-term dot, 0x02 four-term dot, 0x08 multiply, 0x0C max, 0x0D min, 0x0E reciprocal, 0x0F reciprocal square root and 0x13 move. Executing one drives `alu_issue` high for exactly one cycle, in the cycle after the execute edge, with that code on `alu_op` and the instruction address on `alu_pc`. The program counter then advances by one.
- R2: A start pulse while idle loads the program counter from the low 10 bits of `entry_ofs`, and `busy` rises in the next cycle.
- R3: Code 0x24 (call) pushes the address of the call itself and jumps to the low 10 bits of instruction bits 21:10. It issues nothing to the ALU.
- R4: Code 0x21 (return) with a non-empty stack pops the saved address and continues at that address plus one.
- R5: A return executed with an empty stack ends the run. `busy` falls and `done` is high for exactly one cycle.
- R6: The return stack holds 8 entries and is emptied at every start. A call made while 8 entries are held sets `err_overflow` and ends the run with a `done` pulse, without jumping. `err_overflow` stays set until the next start.
- R7: Code 0x22 (flush) issues nothing and only advances the program counter.
- R8: Any other opcode pulses `err_unknown` for one cycle, issues nothing, and the program counter advances by one.
- R9: `load_begin` sets the write pointer to zero. `load_wr` stores `load_data` at the pointer and then increments the pointer. When both are high in the same cycle, `load_begin` wins and nothing is stored.
- R10: While `busy` is high, `load_begin` and `load_wr` have no effect on the store or on the write pointer.
- R11: Every instruction takes one cycle. A run of N non-control instructions ended by an empty-stack return keeps `busy` high for N+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_begin | input | 1 | Reset the instruction-store write pointer |
| load_wr | input | 1 | Write `load_data` at the pointer and increment it |
| load_data | input | 32 | Instruction word to store |
| entry_ofs | input | 16 | Entry word offset; the low 10 bits are used |
| start | input | 1 | Begin a run (ignored while busy) |
| busy | output | 1 | A program is running |
| done | output | 1 | One-cycle pulse when a run ends |
| alu_issue | output | 1 | One-cycle strobe for an arithmetic instruction |
| alu_op | output | 6 | Opcode of the issued instruction |
| alu_pc | output | 10 | Address of the issued instruction |
| err_unknown | output | 1 | One-cycle pulse for an unknown opcode |
| err_overflow | output | 1 | Call attempted with a full stack; held until next start |

## Verification
The assertions assume that `start` is only meaningful while the block is idle. They also assume that every word a run fetches was written beforehand, because an unwritten word decodes to an unknown value. The stimulus drives every input at the falling clock edge. It fills each program, plus the filler words around it, through the load port before starting a run, and it pulses the load strobes during a run only to show that they are ignored. The stack assertions rely on the sequencer never pushing into a full stack or popping an empty one; every call and return pattern the bench uses respects this, including the nine-deep call chain.

// File: rtl/shseq_pkg.sv
package shseq_pkg;

   localparam int OPC_W = 6;

   typedef enum logic [OPC_W-1:0] {
      OP_ADD    = 6'h00,
      OP_DOT3   = 6'h01,
      OP_DOT4   = 6'h02,
      OP_MUL    = 6'h08,
      OP_MAX    = 6'h0C,
      OP_MIN    = 6'h0D,
      OP_RECIP  = 6'h0E,
      OP_RSQRT  = 6'h0F,
      OP_MOVE   = 6'h13,
      OP_RETURN = 6'h21,
      OP_FLUSH  = 6'h22,
      OP_CALL   = 6'h24
   } opcode_e;

   typedef enum logic [2:0] {
      K_ARITH,
      K_CALL,
      K_RET,
      K_NOP,
      K_BAD
   } kind_e;

endpackage

// File: rtl/shseq_progmem.sv
module shseq_progmem #(
   parameter int ADDR_W = 10,
   parameter int WORD_W = 32,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lock,
   input  logic              ld_begin,
   input  logic              ld_wr,
   input  logic [WORD_W-1:0] ld_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   logic [WORD_W-1:0] mem [DEPTH];
   logic [ADDR_W-1:0] wptr;
   logic              do_write;

   assign do_write = !lock && ld_wr && !ld_begin;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr <= '0;
      end else if (!lock) begin
         if (ld_begin)
            wptr <= '0;
         else if (ld_wr)
            wptr <= wptr + ADDR_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (do_write)
         mem[wptr] <= ld_data;
   end

   assign rd_data = mem[rd_addr];

   // R10
   prog_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lock |=> $stable(wptr));

   // R9
   prog_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_begin && !lock) |=> (wptr == '0));

endmodule

// File: rtl/shseq_rstack.sv
module shseq_rstack #(
   parameter int DEPTH  = 8,
   parameter int ADDR_W = 10,
   localparam int SP_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              push,
   input  logic              pop,
   input  logic [ADDR_W-1:0] push_addr,
   output logic [ADDR_W-1:0] top_addr,
   output logic              empty,
   output logic              full
);

   logic [SP_W-1:0]   sp;
   logic [ADDR_W-1:0] ent [DEPTH];

   assign empty = (sp == '0);
   assign full  = (sp == SP_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n)
         sp <= '0;
      else if (clear)
         sp <= '0;
      else if (push && !full)
         sp <= sp + SP_W'(1);
      else if (pop && !empty)
         sp <= sp - SP_W'(1);
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      always_ff @(posedge clk) begin
         if (!rst_n)
            ent[i] <= '0;
         else if (!clear && push && !full && sp == SP_W'(i))
            ent[i] <= push_addr;
      end
   end

   always_comb begin
      top_addr = '0;
      for (int i = 0; i < DEPTH; i++)
         if (sp == SP_W'(i + 1))
            top_addr = ent[i];
   end

   // R6
   stack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sp <= SP_W'(DEPTH));

   // R6
   stack_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !push);

   // R5
   stack_pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> !pop);

endmodule

// File: rtl/shseq_decode.sv
module shseq_decode
   import shseq_pkg::*;
#(
   parameter int WORD_W  = 32,
   parameter int ADDR_W  = 10,
   parameter int OPC_LSB = 26,
   parameter int TGT_LSB = 10,
   parameter int TGT_W   = 12
) (
   input  logic [WORD_W-1:0] instr,
   output logic [OPC_W-1:0]  opc,
   output kind_e             kind,
   output logic [ADDR_W-1:0] target
);

   if (ADDR_W > TGT_W) begin : g_bad_tgt
      $error("target field narrower than program address");
   end
   if (OPC_LSB + OPC_W != WORD_W) begin : g_bad_opc
      $error("opcode field must occupy the top bits of the word");
   end

   logic [TGT_W-1:0] tgt_field;

   assign opc       = instr[OPC_LSB +: OPC_W];
   assign tgt_field = instr[TGT_LSB +: TGT_W];
   assign target    = tgt_field[ADDR_W-1:0];

   always_comb begin
      case (opc)
         OP_ADD, OP_DOT3, OP_DOT4, OP_MUL, OP_MAX,
         OP_MIN, OP_RECIP, OP_RSQRT, OP_MOVE: kind = K_ARITH;
         OP_CALL:                             kind = K_CALL;
         OP_RETURN:                           kind = K_RET;
         OP_FLUSH:                            kind = K_NOP;
         default:                             kind = K_BAD;
      endcase
   end

endmodule

// File: rtl/shader_seq.sv
module shader_seq
   import shseq_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int WORD_W      = 32,
   parameter int ENTRY_W     = 16,
   parameter int STACK_DEPTH = 8,
   parameter int TGT_LSB     = 10,
   parameter int TGT_W       = 12,
   localparam int OPC_LSB    = WORD_W - OPC_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_begin,
   input  logic               load_wr,
   input  logic [WORD_W-1:0]  load_data,
   input  logic [ENTRY_W-1:0] entry_ofs,
   input  logic               start,
   output logic               busy,
   output logic               done,
   output logic               alu_issue,
   output logic [OPC_W-1:0]   alu_op,
   output logic [ADDR_W-1:0]  alu_pc,
   output logic               err_unknown,
   output logic               err_overflow
);

   if (ENTRY_W < ADDR_W) begin : g_bad_entry
      $error("entry offset narrower than program address");
   end
   if (STACK_DEPTH < 1) begin : g_bad_depth
      $error("return stack needs at least one entry");
   end

   logic              running;
   logic [ADDR_W-1:0] pc;
   logic [WORD_W-1:0] instr;
   logic [OPC_W-1:0]  opc;
   kind_e             kind;
   logic [ADDR_W-1:0] target;
   logic [ADDR_W-1:0] ret_addr;
   logic              st_empty, st_full;
   logic              st_clear, st_push, st_pop;

   shseq_progmem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_mem (
      .clk      (clk),
      .rst_n    (rst_n),
      .lock     (running),
      .ld_begin (load_begin),
      .ld_wr    (load_wr),
      .ld_data  (load_data),
      .rd_addr  (pc),
      .rd_data  (instr)
   );

   shseq_decode #(
      .WORD_W (WORD_W), .ADDR_W (ADDR_W), .OPC_LSB (OPC_LSB),
      .TGT_LSB(TGT_LSB), .TGT_W (TGT_W)
   ) u_dec (
      .instr  (instr),
      .opc    (opc),
      .kind   (kind),
      .target (target)
   );

   assign st_clear = !running && start;
   assign st_push  = running && (kind == K_CALL) && !st_full;
   assign st_pop   = running && (kind == K_RET) && !st_empty;

   shseq_rstack #(.DEPTH(STACK_DEPTH), .ADDR_W(ADDR_W)) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (st_clear),
      .push      (st_push),
      .pop       (st_pop),
      .push_addr (pc),
      .top_addr  (ret_addr),
      .empty     (st_empty),
      .full      (st_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         running      <= 1'b0;
         pc           <= '0;
         done         <= 1'b0;
         alu_issue    <= 1'b0;
         alu_op       <= '0;
         alu_pc       <= '0;
         err_unknown  <= 1'b0;
         err_overflow <= 1'b0;
      end else begin
         done        <= 1'b0;
         alu_issue   <= 1'b0;
         err_unknown <= 1'b0;
         if (!running) begin
            if (start) begin
               running      <= 1'b1;
               pc           <= entry_ofs[ADDR_W-1:0];
               err_overflow <= 1'b0;
            end
         end else begin
            case (kind)
               K_ARITH: begin
                  alu_issue <= 1'b1;
                  alu_op    <= opc;
                  alu_pc    <= pc;
                  pc        <= pc + ADDR_W'(1);
               end
               K_CALL: begin
                  if (st_full) begin
                     err_overflow <= 1'b1;
                     running      <= 1'b0;
                     done         <= 1'b1;
                  end else begin
                     pc <= target;
                  end
               end
               K_RET: begin
                  if (st_empty) begin
                     running <= 1'b0;
                     done    <= 1'b1;
                  end else begin
                     pc <= ret_addr + ADDR_W'(1);
                  end
               end
               K_NOP: pc <= pc + ADDR_W'(1);
               default: begin
                  err_unknown <= 1'b1;
                  pc          <= pc + ADDR_W'(1);
               end
            endcase
         end
      end
   end

   assign busy = running;

   // R1
   issue_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alu_issue |-> $past(busy));

   // R2
   start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R6
   ovf_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_overflow) |-> done);

   // R8
   unknown_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_unknown |-> $past(busy));

endmodule

// File: tb/tb_shader_seq.sv
module tb_shader_seq;

   localparam logic [5:0] C_ADD = 6'h00, C_MUL = 6'h08, C_DOT4 = 6'h02,
                          C_MOVE = 6'h13, C_RET = 6'h21, C_CALL = 6'h24;

   // {opcode, expected issue, expected unknown, expected busy cycles}
   localparam logic [11:0] VEC [13] = '{
      {6'h00, 1'b1, 1'b0, 4'd2}, {6'h01, 1'b1, 1'b0, 4'd2},
      {6'h02, 1'b1, 1'b0, 4'd2}, {6'h08, 1'b1, 1'b0, 4'd2},
      {6'h0C, 1'b1, 1'b0, 4'd2}, {6'h0D, 1'b1, 1'b0, 4'd2},
      {6'h0E, 1'b1, 1'b0, 4'd2}, {6'h0F, 1'b1, 1'b0, 4'd2},
      {6'h13, 1'b1, 1'b0, 4'd2}, {6'h22, 1'b0, 1'b0, 4'd2},
      {6'h21, 1'b0, 1'b0, 4'd1}, {6'h3F, 1'b0, 1'b1, 4'd2},
      {6'h05, 1'b0, 1'b1, 4'd2}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        load_begin = 1'b0, load_wr = 1'b0, start = 1'b0;
   logic [31:0] load_data = '0;
   logic [15:0] entry_ofs = '0;
   logic        busy, done, alu_issue, err_unknown, err_overflow;
   logic [5:0]  alu_op;
   logic [9:0]  alu_pc;

   int checks = 0, failures = 0;
   int busy_cnt, done_cnt, unk_cnt, issue_cnt;
   int issue_pc [16];
   int issue_op [16];
   logic [31:0] img [1024];

   always #5 clk = ~clk;

   shader_seq dut (
      .clk(clk), .rst_n(rst_n), .load_begin(load_begin), .load_wr(load_wr),
      .load_data(load_data), .entry_ofs(entry_ofs), .start(start),
      .busy(busy), .done(done), .alu_issue(alu_issue), .alu_op(alu_op),
      .alu_pc(alu_pc), .err_unknown(err_unknown), .err_overflow(err_overflow)
   );

   always @(posedge clk) begin
      #2;
      if (busy) busy_cnt++;
      if (done) done_cnt++;
      if (err_unknown) unk_cnt++;
      if (alu_issue) begin
         if (issue_cnt < 16) begin
            issue_pc[issue_cnt] = int'(alu_pc);
            issue_op[issue_cnt] = int'(alu_op);
         end
         issue_cnt++;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] w_op(input logic [5:0] op);
      return {op, 26'd0};
   endfunction

   function automatic logic [31:0] w_call(input int tgt);
      return {C_CALL, 4'd0, 12'(tgt), 10'd0};
   endfunction

   task automatic fill_ret();
      for (int i = 0; i < 1024; i++) img[i] = w_op(C_RET);
   endtask

   task automatic load_image(input int n);
      @(negedge clk); load_begin = 1'b1;
      @(negedge clk); load_begin = 1'b0;
      for (int i = 0; i < n; i++) begin
         load_wr = 1'b1; load_data = img[i];
         @(negedge clk);
      end
      load_wr = 1'b0;
   endtask

   task automatic append(input logic [31:0] w);
      load_wr = 1'b1; load_data = w;
      @(negedge clk);
      load_wr = 1'b0;
   endtask

   task automatic run(input logic [15:0] e, input bit poke);
      busy_cnt = 0; done_cnt = 0; unk_cnt = 0; issue_cnt = 0;
      entry_ofs = e;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (poke) begin
         load_begin = 1'b1; load_wr = 1'b1; load_data = w_op(C_ADD);
         @(negedge clk);
         load_begin = 1'b0; load_wr = 1'b0;
      end
      for (int t = 0; t < 4000; t++) begin
         if (done_cnt > 0) break;
         @(negedge clk);
      end
      chk("R5 run ends with done", done_cnt, 1);
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R5 reset busy", int'(busy), 0);
      chk("R5 reset done", int'(done), 0);
      chk("R1 reset issue", int'(alu_issue), 0);
      chk("R8 reset unknown", int'(err_unknown), 0);
      chk("R6 reset overflow", int'(err_overflow), 0);

      // Table: one instruction then an empty-stack return (R1 R7 R8 R11)
      foreach (VEC[k]) begin
         fill_ret();
         img[0] = w_op(VEC[k][11:6]);
         load_image(2);
         run(16'd0, 1'b0);
         chk("R1/R7 table issue count", issue_cnt, int'(VEC[k][5]));
         chk("R8 table unknown count", unk_cnt, int'(VEC[k][4]));
         chk("R11 table busy cycles", busy_cnt, int'(VEC[k][3:0]));
         if (VEC[k][5]) begin
            chk("R1 table op", issue_op[0], int'(VEC[k][11:6]));
            chk("R1 table pc", issue_pc[0], 0);
         end
      end

      // R3 R4: call then return into the caller
      fill_ret();
      img[0] = w_op(C_ADD); img[1] = w_call(10); img[2] = w_op(C_MUL);
      img[10] = w_op(C_DOT4);
      load_image(12);
      run(16'd0, 1'b0);
      chk("R3 call issues", issue_cnt, 3);
      chk("R3 pc after call", issue_pc[1], 10);
      chk("R3 op after call", issue_op[1], int'(C_DOT4));
      chk("R4 pc after return", issue_pc[2], 2);
      chk("R4 op after return", issue_op[2], int'(C_MUL));
      chk("R11 call run busy", busy_cnt, 6);

      // R2: entry offset uses low 10 bits
      fill_ret();
      img[32] = w_op(C_MOVE);
      load_image(34);
      run(16'h0420, 1'b0);
      chk("R2 entry issue count", issue_cnt, 1);
      chk("R2 entry pc", issue_pc[0], 32);

      // R6: nine nested calls overflow the stack; R10: load strobes while busy
      fill_ret();
      for (int i = 0; i < 9; i++) img[100 + i] = w_call(101 + i);
      img[109] = w_op(C_ADD);
      img[110] = w_op(C_RET);
      load_image(111);
      run(16'd100, 1'b1);
      chk("R6 overflow flag", int'(err_overflow), 1);
      chk("R6 overflow no issue", issue_cnt, 0);
      chk("R6 overflow busy cycles", busy_cnt, 9);
      @(negedge clk);
      chk("R6 overflow flag held", int'(err_overflow), 1);

      // R6: stack emptied at start, flag cleared
      run(16'd109, 1'b0);
      chk("R6 cleared stack issue", issue_cnt, 1);
      chk("R6 cleared stack busy", busy_cnt, 2);
      chk("R6 flag cleared by start", int'(err_overflow), 0);

      // R10: pointer still at 111 after ignored strobes
      @(negedge clk);
      append(w_op(C_MUL));
      append(w_op(C_RET));
      run(16'd111, 1'b0);
      chk("R10 appended op", issue_op[0], int'(C_MUL));
      chk("R10 appended pc", issue_pc[0], 111);
      chk("R10 appended busy", busy_cnt, 2);

      // R9: begin and write together store nothing
      @(negedge clk);
      load_begin = 1'b1; load_wr = 1'b1; load_data = w_op(C_MUL);
      @(negedge clk);
      load_begin = 1'b0; load_wr = 1'b0;
      append(w_op(C_ADD));
      append(w_op(C_RET));
      run(16'd0, 1'b0);
      chk("R9 begin wins op", issue_op[0], int'(C_ADD));
      chk("R9 begin wins busy", busy_cnt, 2);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule